// File: doc/BRIEF.md
# Flash erase command sequencer

This block models the command front end of a parallel boot-sector flash as far as erasing goes. It watches byte-wide bus writes (address, data, one-cycle write strobe) and recognises a six-write framing: two unlock writes, an erase set-up write, two more unlock writes, and a final command write. If the final write is a sector erase, the addressed sector is marked in a one-bit-per-sector buffer and an acceptance window opens. Further sector erase writes during the window add sectors and restart it. If the final write is a chip erase, every sector is marked and work starts at once.

When the window runs out, a simulated embedded erase runs. It first spends a preprogram phase of a fixed number of cycles per selected sector, which stands for writing zeros and verifying them. It then spends an erase phase of a fixed number of cycles per selected sector. After that it clears the buffer and returns to array read. The address decode for unlock writes uses the low 11 address bits. The sector index is the top `$clog2(SECTORS)` address bits.

State machine states:
- `ST_READ`: array read, idle.
- `ST_UL1`, `ST_UL2`: the first unlock pair has been seen.
- `ST_SETUP`: the set-up command has been seen.
- `ST_UL3`, `ST_UL4`: the second unlock pair has been seen.
- `ST_WINDOW`: the acceptance window is open.
- `ST_PREPROG`: preprogram phase.
- `ST_ERASE`: erase phase.

Transitions:
- Each expected write advances the framing by one state.
- Any unexpected write returns to `ST_READ`.
- `ST_UL4` goes to `ST_WINDOW` on a sector erase and to `ST_PREPROG` on a chip erase.
- `ST_WINDOW` restarts itself on a sector erase.
- `ST_WINDOW` aborts to `ST_READ` on any other command except suspend.
- `ST_WINDOW` goes to `ST_PREPROG` when its timer expires.
- `ST_PREPROG` goes to `ST_ERASE` when its count ends, and `ST_ERASE` goes to `ST_READ` when its count ends.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy, timer_closed, preprog and erasing are 0 and sel_mask is 0.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address, open the window. From the next cycle busy=1 and timer_closed=0, and sel_mask has the single bit set whose index is the top address bits of the last write.
- R3: A write with a wrong value or wrong low-11-bit address in any of the first five framing positions returns the block to idle. A following 0x30 write then has no effect.
- R4: If the sixth write is 0x10@0x555, then from the next cycle preprog=1, timer_closed=1 and every bit of sel_mask is set.
- R5: With no further write, the window stays open for exactly WINDOW_CYC cycles after the last accepted sector write, then preprog rises together with timer_closed.
- R6: Each 0x30 write during the window ORs its sector into sel_mask, in any order, and restarts the window count.
- R7: A 0xB0 write during the window changes neither sel_mask nor the window count.
- R8: Any other write during the window clears sel_mask and drops busy on the next cycle.
- R9: preprog stays high for N*PREP_CYC cycles and erasing then stays high for N*ERASE_CYC cycles, where N is the number of set bits of sel_mask.
- R10: Writes during preprog or erasing have no effect on any output.
- R11: When the erase phase ends, busy, timer_closed and erasing fall and sel_mask is cleared in the same cycle.
- R12: A write arriving on the window's last cycle is acted on (add or abort) instead of the window expiring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | ADDR_W | Write address |
| bus_din | input | 8 | Write data / command byte |
| busy | output | 1 | High from window open until erase completes |
| timer_closed | output | 1 | Erase timer status: 0 while sectors may be added, 1 once work began |
| preprog | output | 1 | Preprogram phase active |
| erasing | output | 1 | Erase phase active |
| sel_mask | output | SECTORS | Sector erase buffer, one bit per sector |

## Verification
The assertions check several relations on every cycle:
- timer_closed never appears without busy;
- the two phases never overlap;
- the buffer is non-empty exactly while busy;
- the buffer only grows in the window and is frozen once work begins;
- erasing always follows preprog, and its end returns the block to idle;
- a chip erase enters work with a full buffer.

Exact window lengths, phase lengths, the rejection of broken unlock framing, the effect of suspend and abort writes, and the precedence of a write landing on the window's last cycle can only be shown by the bench's scenarios against its reference model.

// File: rtl/fes_pkg.sv
package fes_pkg;

    localparam int UL_W = 11;
    localparam logic [UL_W-1:0] ADDR_A = 11'h555;
    localparam logic [UL_W-1:0] ADDR_B = 11'h2AA;

    localparam logic [7:0] D_KEY_A   = 8'hAA;
    localparam logic [7:0] D_KEY_B   = 8'h55;
    localparam logic [7:0] D_SETUP   = 8'h80;
    localparam logic [7:0] D_SECTOR  = 8'h30;
    localparam logic [7:0] D_CHIP    = 8'h10;
    localparam logic [7:0] D_SUSPEND = 8'hB0;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UL1,
        ST_UL2,
        ST_SETUP,
        ST_UL3,
        ST_UL4,
        ST_WINDOW,
        ST_PREPROG,
        ST_ERASE
    } fes_state_e;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_KEY_A,
        CK_KEY_B,
        CK_SETUP,
        CK_SECTOR,
        CK_CHIP,
        CK_SUSPEND,
        CK_OTHER
    } fes_kind_e;

endpackage

// File: rtl/fes_cmd_decode.sv
module fes_cmd_decode
    import fes_pkg::*;
(
    input  logic            we,
    input  logic [UL_W-1:0] addr_lo,
    input  logic [7:0]      data,
    output fes_kind_e       kind
);
    always_comb begin
        if (!we)
            kind = CK_NONE;
        else if (data == D_KEY_A && addr_lo == ADDR_A)
            kind = CK_KEY_A;
        else if (data == D_KEY_B && addr_lo == ADDR_B)
            kind = CK_KEY_B;
        else if (data == D_SETUP && addr_lo == ADDR_A)
            kind = CK_SETUP;
        else if (data == D_SECTOR)
            kind = CK_SECTOR;
        else if (data == D_CHIP && addr_lo == ADDR_A)
            kind = CK_CHIP;
        else if (data == D_SUSPEND)
            kind = CK_SUSPEND;
        else
            kind = CK_OTHER;
    end
endmodule

// File: rtl/fes_sector_map.sv
module fes_sector_map #(
    parameter int ADDR_W  = 18,
    parameter int SECTORS = 8
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [SECTORS-1:0] hot
);
    localparam int SEL_W = $clog2(SECTORS);

    logic [SEL_W-1:0] idx;
    assign idx = addr[ADDR_W-1 -: SEL_W];

    for (genvar i = 0; i < SECTORS; i++) begin : g_sect
        assign hot[i] = (idx == SEL_W'(i));
    end
endmodule

// File: rtl/fes_down_ctr.sv
module fes_down_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (en && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int SECTORS    = 8,
    parameter int WINDOW_CYC = 64,
    parameter int PREP_CYC   = 4,
    parameter int ERASE_CYC  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_din,
    output logic               busy,
    output logic               timer_closed,
    output logic               preprog,
    output logic               erasing,
    output logic [SECTORS-1:0] sel_mask
);
    localparam int MAX_PH = (PREP_CYC > ERASE_CYC) ? PREP_CYC : ERASE_CYC;
    localparam int WIN_W  = $clog2(WINDOW_CYC + 1);
    localparam int PH_W   = $clog2(SECTORS * MAX_PH + 1);
    localparam int CNT_W  = $clog2(SECTORS + 1);

    fes_state_e         state_q, state_d;
    logic [SECTORS-1:0] mask_q, mask_d;
    fes_kind_e          kind;
    logic [SECTORS-1:0] sect_hot;
    logic               win_load, win_zero;
    logic               ph_load, ph_zero;
    logic [PH_W-1:0]    ph_val;
    logic [CNT_W-1:0]   nsel;

    fes_cmd_decode u_dec (
        .we      (bus_we),
        .addr_lo (bus_addr[UL_W-1:0]),
        .data    (bus_din),
        .kind    (kind)
    );

    fes_sector_map #(.ADDR_W(ADDR_W), .SECTORS(SECTORS)) u_map (
        .addr (bus_addr),
        .hot  (sect_hot)
    );

    fes_down_ctr #(.W(WIN_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_load),
        .load_val (WIN_W'(WINDOW_CYC - 1)),
        .en       (state_q == ST_WINDOW),
        .zero     (win_zero)
    );

    fes_down_ctr #(.W(PH_W)) u_ph (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .en       (state_q == ST_PREPROG || state_q == ST_ERASE),
        .zero     (ph_zero)
    );

    // next state and buffer
    always_comb begin
        state_d  = state_q;
        mask_d   = mask_q;
        win_load = 1'b0;
        unique case (state_q)
            ST_READ: begin
                if (kind == CK_KEY_A) state_d = ST_UL1;
            end
            ST_UL1: begin
                if (kind == CK_KEY_B)      state_d = ST_UL2;
                else if (kind != CK_NONE)  state_d = ST_READ;
            end
            ST_UL2: begin
                if (kind == CK_SETUP)      state_d = ST_SETUP;
                else if (kind != CK_NONE)  state_d = ST_READ;
            end
            ST_SETUP: begin
                if (kind == CK_KEY_A)      state_d = ST_UL3;
                else if (kind != CK_NONE)  state_d = ST_READ;
            end
            ST_UL3: begin
                if (kind == CK_KEY_B)      state_d = ST_UL4;
                else if (kind != CK_NONE)  state_d = ST_READ;
            end
            ST_UL4: begin
                if (kind == CK_SECTOR) begin
                    state_d  = ST_WINDOW;
                    mask_d   = sect_hot;
                    win_load = 1'b1;
                end else if (kind == CK_CHIP) begin
                    state_d = ST_PREPROG;
                    mask_d  = '1;
                end else if (kind != CK_NONE) begin
                    state_d = ST_READ;
                end
            end
            ST_WINDOW: begin
                if (kind == CK_SECTOR) begin
                    mask_d   = mask_q | sect_hot;
                    win_load = 1'b1;
                end else if (kind == CK_NONE || kind == CK_SUSPEND) begin
                    if (win_zero) state_d = ST_PREPROG;
                end else begin
                    state_d = ST_READ;
                    mask_d  = '0;
                end
            end
            ST_PREPROG: begin
                if (ph_zero) state_d = ST_ERASE;
            end
            ST_ERASE: begin
                if (ph_zero) begin
                    state_d = ST_READ;
                    mask_d  = '0;
                end
            end
            default: begin
                state_d = ST_READ;
                mask_d  = '0;
            end
        endcase
    end

    // phase counter reload on each phase entry
    always_comb begin
        nsel    = CNT_W'($countones(mask_d));
        ph_load = (state_d == ST_PREPROG && state_q != ST_PREPROG) ||
                  (state_d == ST_ERASE   && state_q != ST_ERASE);
        if (state_d == ST_PREPROG)
            ph_val = PH_W'(nsel * PREP_CYC - 1);
        else
            ph_val = PH_W'(nsel * ERASE_CYC - 1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READ;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
        end
    end

    // outputs
    always_comb begin
        busy         = 1'b0;
        timer_closed = 1'b0;
        preprog      = 1'b0;
        erasing      = 1'b0;
        unique case (state_q)
            ST_WINDOW:  busy = 1'b1;
            ST_PREPROG: begin busy = 1'b1; timer_closed = 1'b1; preprog = 1'b1; end
            ST_ERASE:   begin busy = 1'b1; timer_closed = 1'b1; erasing = 1'b1; end
            default:    ;
        endcase
        sel_mask = mask_q;
    end
endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
    parameter int SECTORS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               timer_closed,
    input logic               preprog,
    input logic               erasing,
    input logic [SECTORS-1:0] sel_mask
);
    AST_CLOSED_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        timer_closed |-> busy); // R5

    AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(preprog && erasing)); // R9

    AST_BUSY_HAS_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sel_mask != '0)); // R2

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sel_mask == '0)); // R8

    AST_WINDOW_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !timer_closed) |=> (!busy || ((sel_mask & $past(sel_mask)) == $past(sel_mask)))); // R6

    AST_WORK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        timer_closed |=> (!timer_closed || $stable(sel_mask))); // R10

    AST_ERASE_AFTER_PREP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erasing) |-> $past(preprog)); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erasing) |-> (!busy && !timer_closed)); // R11

    AST_CHIP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(timer_closed) && !$past(busy)) |-> (&sel_mask)); // R4
endmodule

bind flash_erase_seq fes_checker #(.SECTORS(SECTORS)) u_fes_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .timer_closed (timer_closed),
    .preprog      (preprog),
    .erasing      (erasing),
    .sel_mask     (sel_mask)
);

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;
    localparam int ADDR_W = 18;
    localparam int NS     = 8;
    localparam int WIN    = 20;
    localparam int PREP   = 3;
    localparam int ERA    = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_din = '0;
    logic              busy, timer_closed, preprog, erasing;
    logic [NS-1:0]     sel_mask;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    flash_erase_seq #(.ADDR_W(ADDR_W), .SECTORS(NS), .WINDOW_CYC(WIN),
                      .PREP_CYC(PREP), .ERASE_CYC(ERA)) u_flash_erase_seq (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_din(bus_din), .busy(busy), .timer_closed(timer_closed),
        .preprog(preprog), .erasing(erasing), .sel_mask(sel_mask)
    );

    // behavioural reference: mode 0 idle, 1 window, 2 preprogram, 3 erase
    int        m_mode = 0;
    int        m_prog = 0;
    int        m_rem  = 0;
    logic [NS-1:0] m_mask = '0;

    function automatic bit key_ok(int p, logic [ADDR_W-1:0] a, logic [7:0] d);
        case (p)
            0, 3:    return d == 8'hAA && a[10:0] == 11'h555;
            1, 4:    return d == 8'h55 && a[10:0] == 11'h2AA;
            2:       return d == 8'h80 && a[10:0] == 11'h555;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_prog = 0; m_rem = 0; m_mask = '0;
        end else begin
            logic [NS-1:0] hot;
            hot = NS'(1) << bus_addr[ADDR_W-1 -: 3];
            case (m_mode)
                0: if (bus_we) begin
                    if (m_prog == 5) begin
                        if (bus_din == 8'h30) begin
                            m_mode = 1; m_mask = hot; m_rem = WIN;
                        end else if (bus_din == 8'h10 && bus_addr[10:0] == 11'h555) begin
                            m_mode = 2; m_mask = '1; m_rem = NS * PREP;
                        end
                        m_prog = 0;
                    end else if (key_ok(m_prog, bus_addr, bus_din)) begin
                        m_prog++;
                    end else begin
                        m_prog = 0;
                    end
                end
                1: if (bus_we && bus_din == 8'h30) begin
                    m_mask |= hot; m_rem = WIN;
                end else if (bus_we && bus_din != 8'hB0) begin
                    m_mode = 0; m_mask = '0;
                end else begin
                    m_rem--;
                    if (m_rem == 0) begin
                        m_mode = 2; m_rem = $countones(m_mask) * PREP;
                    end
                end
                2: begin
                    m_rem--;
                    if (m_rem == 0) begin
                        m_mode = 3; m_rem = $countones(m_mask) * ERA;
                    end
                end
                default: begin
                    m_rem--;
                    if (m_rem == 0) begin
                        m_mode = 0; m_mask = '0;
                    end
                end
            endcase
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(busy == (m_mode != 0), "R2 busy", busy, m_mode != 0);
            chk(timer_closed == (m_mode >= 2), "R5 timer_closed", timer_closed, m_mode >= 2);
            chk(preprog == (m_mode == 2), "R9 preprog", preprog, m_mode == 2);
            chk(erasing == (m_mode == 3), "R9 erasing", erasing, m_mode == 3);
            chk(sel_mask == m_mask, "R6 sel_mask", sel_mask, m_mask);
        end
    end

    task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_din = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic prefix();
        wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55); wr(18'h00555, 8'h80);
        wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55);
    endtask

    function automatic logic [ADDR_W-1:0] sa(int s);
        return ADDR_W'(s) << 15;
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    // counts negedges while sig matches lvl (sig chosen by sel)
    task automatic measure(int sel, output int n);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            logic v;
            v = (sel == 0) ? (busy && !timer_closed) : (sel == 1) ? preprog : erasing;
            if (!v) break;
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(!busy && !timer_closed && !preprog && !erasing && sel_mask == 0,
            "R1 reset", {busy, timer_closed, preprog, erasing}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && sel_mask == 0, "R1 after release", busy, 0);

        // single sector, timed window and phases
        prefix(); wr(sa(5), 8'h30);
        chk(busy && !timer_closed && sel_mask == 8'h20, "R2 window open", sel_mask, 8'h20);
        measure(0, n);
        chk(n == WIN, "R5 window length", n, WIN);
        measure(1, n);
        chk(n == PREP, "R9 preprog length", n, PREP);
        wr(18'h00555, 8'hF0); wr(sa(2), 8'h30);
        chk(sel_mask == 8'h20 && timer_closed, "R10 writes ignored", sel_mask, 8'h20);
        wait_idle();
        chk(!busy && !timer_closed && !erasing && sel_mask == 0, "R11 back to read", sel_mask, 0);

        // broken framing
        wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55); wr(18'h00555, 8'h80);
        wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h54); wr(sa(1), 8'h30);
        repeat (2) @(negedge clk);
        chk(!busy && sel_mask == 0, "R3 bad data", busy, 0);
        wr(18'h00554, 8'hAA); wr(18'h002AA, 8'h55); wr(18'h00555, 8'h80);
        wr(18'h00555, 8'hAA); wr(18'h002AA, 8'h55); wr(sa(1), 8'h30);
        repeat (2) @(negedge clk);
        chk(!busy && sel_mask == 0, "R3 bad address", busy, 0);

        // chip erase
        prefix(); wr(18'h00555, 8'h10);
        chk(preprog && timer_closed && sel_mask == 8'hFF, "R4 chip erase", sel_mask, 8'hFF);
        measure(1, n);
        chk(n == NS * PREP, "R9 chip preprog length", n, NS * PREP);
        measure(2, n);
        chk(n == NS * ERA, "R9 chip erase length", n, NS * ERA);
        chk(!busy, "R11 chip done", busy, 0);

        // multi-sector accumulation, suspend ignored
        prefix(); wr(sa(6), 8'h30);
        repeat (5) @(negedge clk);
        wr(sa(1), 8'h30); wr(sa(3), 8'h30); wr(sa(6), 8'h30);
        chk(sel_mask == 8'h4A, "R6 accumulate", sel_mask, 8'h4A);
        wr(sa(0), 8'hB0);
        chk(sel_mask == 8'h4A && !timer_closed, "R7 suspend ignored", sel_mask, 8'h4A);
        measure(0, n);
        chk(n == WIN - 2, "R7 window not restarted", n, WIN - 2);
        measure(1, n);
        chk(n == 3 * PREP, "R9 three-sector preprog", n, 3 * PREP);
        wait_idle();

        // abort
        prefix(); wr(sa(4), 8'h30); wr(18'h00555, 8'hF0);
        chk(!busy && sel_mask == 0, "R8 abort", sel_mask, 0);

        // write on the window's last cycle
        prefix(); wr(sa(2), 8'h30);
        repeat (WIN - 2) @(negedge clk);
        wr(sa(7), 8'h30);
        chk(!timer_closed && sel_mask == 8'h84, "R12 late add", sel_mask, 8'h84);
        repeat (WIN - 2) @(negedge clk);
        wr(18'h00555, 8'hF0);
        chk(!busy && sel_mask == 0, "R12 late abort", sel_mask, 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        done = 1'b1;
        total++; bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule